// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This unit carries out single-bit instructions of a small 8-bit processor against one byte of data memory. The core hands it a decoded operation code, a 16-bit operand word, the upper nibble of the original opcode, the current carry flag and the accumulator. The unit reads the addressed byte through a synchronous port with one cycle of read latency. It computes the result, writes the byte back when the operation calls for it, and returns the new carry and the N and Z flags together with a one-cycle done pulse.

Operations fall into three groups. The carry-logic group merges one memory bit into the carry and never stores anything. The bit-update group changes one bit of the byte and stores it. The test group compares the accumulator with the byte and merges the accumulator into it as a mask. The packed forms carry both the byte address and the bit number in the operand word. The direct-page forms take a full address and pick the bit from the opcode nibble.

Top module: `mem_bit_unit`

## Requirements
- R1: For codes 0 to 7 (packed forms) the byte address is {3'b000, operand[12:0]} and the bit number is operand[15:13]. For codes 8 to 15 the address is the whole operand.
- R2: Codes 0 (AND), 1 (AND with inverted bit), 2 (OR), 3 (OR with inverted bit) and 4 (XOR) set carry_out to carry_in combined with the selected memory bit. None of them writes memory.
- R3: Code 5 loads the selected bit into carry_out without a write. Code 6 writes back the byte with only the selected bit replaced by carry_in.
- R4: Code 7 writes back the byte with the selected bit inverted and every other bit unchanged.
- R5: Code 8 uses page_sel[3:1] as the bit number. It clears that bit when page_sel[0] is 1 and sets it when page_sel[0] is 0, then writes the byte back.
- R6: Codes 9 (test-and-set) and 10 (test-and-clear) set flag_n to bit 7 and flag_z to zero-ness of the 8-bit value acc minus the byte. Code 9 writes (byte & ~acc) | acc and code 10 writes byte & ~acc.
- R7: mem_rd is high for exactly the cycle after start is accepted. For operations without a write, done pulses two cycles after that. For operations with a write, mem_wr is high two cycles after the read and done pulses in the following cycle. mem_rd and mem_wr are never high together, and done lasts one cycle.
- R8: start is accepted only while busy is low. A start during a busy cycle starts no second access and does not alter the running operation.
- R9: Synchronous reset, including in the middle of an operation, leaves busy, done, mem_rd and mem_wr low and clears carry_out, flag_n and flag_z.
- R10: Codes 11 to 15 read the byte, write nothing, and finish after the same latency as the carry-logic group.
- R11: carry_out equals carry_in after every code from 6 to 15. flag_n and flag_z keep their previous values after every code other than 9 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 4 | Operation code 0 to 15 |
| operand | input | 16 | Packed bit address or full byte address |
| page_sel | input | 4 | Opcode bits 7:4 for the direct-page set/clear form |
| carry_in | input | 1 | Current carry flag |
| acc | input | 8 | Accumulator value |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Resulting carry flag |
| flag_n | output | 1 | Resulting negative flag |
| flag_z | output | 1 | Resulting zero flag |

## Verification
The bench hits the packed word with all three top bits set, so an address slice that is one bit too wide leaks into bit 13 and fails the address check. It drives each carry-logic code with both values of the selected bit, which exposes any inversion bound to the wrong code. Test-and-set is run with acc equal to the byte and test-and-clear with acc above it. A subtraction in the wrong order then gives the wrong Z or N, and a swapped mask gives the wrong stored byte. A second start issued in the read cycle and a reset in mid-operation show whether the sequencer restarts or leaves a strobe high.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_ANDN = 4'd1,
    OP_OR   = 4'd2,
    OP_ORN  = 4'd3,
    OP_XOR  = 4'd4,
    OP_LDC  = 4'd5,
    OP_STC  = 4'd6,
    OP_NOT  = 4'd7,
    OP_DPB  = 4'd8,
    OP_TSET = 4'd9,
    OP_TCLR = 4'd10
  } mbu_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_CALC  = 2'd2,
    S_WRITE = 2'd3
  } mbu_state_e;
endpackage

// File: rtl/mbu_decode.sv
module mbu_decode
  import mbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int PK_AW = ADDR_W - IDX_W
) (
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] operand,
  input  logic [IDX_W:0]    page_sel,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              dp_clear,
  output logic              need_wr
);
  logic packed_form;

  assign packed_form = (op[3] == 1'b0);

  always_comb begin
    if (packed_form) begin
      byte_addr = {{IDX_W{1'b0}}, operand[PK_AW-1:0]};
      bit_idx   = operand[ADDR_W-1 -: IDX_W];
    end else begin
      byte_addr = operand;
      bit_idx   = page_sel[IDX_W:1];
    end
  end

  assign dp_clear = page_sel[0];
  assign need_wr  = (op == OP_STC) || (op == OP_NOT) || (op == OP_DPB) ||
                    (op == OP_TSET) || (op == OP_TCLR);
endmodule

// File: rtl/mbu_alu.sv
module mbu_alu
  import mbu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [3:0]        op,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              dp_clear,
  input  logic              cin,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] new_byte,
  output logic              new_carry,
  output logic              upd_nz,
  output logic              res_n,
  output logic              res_z
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] diff;
  logic              sel;

  assign mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
  assign sel  = rdata[bit_idx];
  assign diff = acc - rdata;

  always_comb begin
    new_byte  = rdata;
    new_carry = cin;
    upd_nz    = 1'b0;
    case (op)
      OP_AND:  new_carry = cin & sel;
      OP_ANDN: new_carry = cin & ~sel;
      OP_OR:   new_carry = cin | sel;
      OP_ORN:  new_carry = cin | ~sel;
      OP_XOR:  new_carry = cin ^ sel;
      OP_LDC:  new_carry = sel;
      OP_STC:  new_byte  = cin ? (rdata | mask) : (rdata & ~mask);
      OP_NOT:  new_byte  = rdata ^ mask;
      OP_DPB:  new_byte  = dp_clear ? (rdata & ~mask) : (rdata | mask);
      OP_TSET: begin
        new_byte = (rdata & ~acc) | acc;
        upd_nz   = 1'b1;
      end
      OP_TCLR: begin
        new_byte = rdata & ~acc;
        upd_nz   = 1'b1;
      end
      default: ;
    endcase
  end

  assign res_n = diff[DATA_W-1];
  assign res_z = (diff == '0);
endmodule

// File: rtl/mbu_seq.sv
module mbu_seq
  import mbu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic need_wr,
  output logic accept,
  output logic in_calc,
  output logic busy,
  output logic rd_o,
  output logic wr_o,
  output logic done_o
);
  mbu_state_e state;

  assign accept  = (state == S_IDLE) && start;
  assign in_calc = (state == S_CALC);
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_READ;
          rd_o  <= 1'b1;
        end
        S_READ: begin
          rd_o  <= 1'b0;
          state <= S_CALC;
        end
        S_CALC: if (need_wr) begin
          state <= S_WRITE;
          wr_o  <= 1'b1;
        end else begin
          state  <= S_IDLE;
          done_o <= 1'b1;
        end
        default: begin
          wr_o   <= 1'b0;
          done_o <= 1'b1;
          state  <= S_IDLE;
        end
      endcase
    end
  end

  AST_RD_SINGLE:   assert property (@(posedge clk) disable iff (rst) rd_o |=> !rd_o); // R7
  AST_RD_WR_EXCL:  assert property (@(posedge clk) disable iff (rst) !(rd_o && wr_o)); // R7
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst) $rose(wr_o) |-> $past(rd_o, 2)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!rd_o && !wr_o && !done_o && !busy)); // R9
endmodule

// File: rtl/mem_bit_unit.sv
module mem_bit_unit
  import mbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] operand,
  input  logic [IDX_W:0]    page_sel,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              carry_out,
  output logic              flag_n,
  output logic              flag_z
);
  logic [ADDR_W-1:0] dec_addr;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_clr, dec_wr;
  logic [3:0]        op_q;
  logic [IDX_W-1:0]  idx_q;
  logic              clr_q, wr_q, cin_q;
  logic [DATA_W-1:0] acc_q;
  logic              accept, in_calc;
  logic [DATA_W-1:0] alu_byte;
  logic              alu_c, alu_upd, alu_n, alu_z;

  mbu_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .op(op), .operand(operand), .page_sel(page_sel),
    .byte_addr(dec_addr), .bit_idx(dec_idx), .dp_clear(dec_clr), .need_wr(dec_wr)
  );

  mbu_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .need_wr(wr_q),
    .accept(accept), .in_calc(in_calc), .busy(busy),
    .rd_o(mem_rd), .wr_o(mem_wr), .done_o(done)
  );

  mbu_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .bit_idx(idx_q), .dp_clear(clr_q), .cin(cin_q), .acc(acc_q),
    .rdata(mem_rdata), .new_byte(alu_byte), .new_carry(alu_c),
    .upd_nz(alu_upd), .res_n(alu_n), .res_z(alu_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= '0;
      idx_q     <= '0;
      clr_q     <= 1'b0;
      wr_q      <= 1'b0;
      cin_q     <= 1'b0;
      acc_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      carry_out <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
    end else if (accept) begin
      op_q     <= op;
      idx_q    <= dec_idx;
      clr_q    <= dec_clr;
      wr_q     <= dec_wr;
      cin_q    <= carry_in;
      acc_q    <= acc;
      mem_addr <= dec_addr;
    end else if (in_calc) begin
      mem_wdata <= alu_byte;
      carry_out <= alu_c;
      if (alu_upd) begin
        flag_n <= alu_n;
        flag_z <= alu_z;
      end
    end
  end

  AST_WR_STORE_OPS: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (op_q inside {OP_STC, OP_NOT, OP_DPB, OP_TSET, OP_TCLR})); // R10
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr == $past(mem_addr, 2))); // R4
  AST_NZ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !(op_q inside {OP_TSET, OP_TCLR})) |-> ($stable(flag_n) && $stable(flag_z))); // R11
endmodule

// File: tb/mem_bit_unit_test.sv
`timescale 1ns/1ps
module mem_bit_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] operand = '0;
  logic [3:0]  page_sel = '0;
  logic        carry_in = 1'b0;
  logic [7:0]  acc = '0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic        busy, done, carry_out, flag_n, flag_z;

  logic [7:0]  bmem [256];
  logic        pl_en = 1'b0;
  logic [7:0]  pl_a = '0;
  logic [7:0]  pl_d = '0;

  int checks = 0;
  int errors = 0;
  logic mdl_n = 1'b0;
  logic mdl_z = 1'b0;

  always #4 clk = ~clk;

  mem_bit_unit uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .operand(operand),
    .page_sel(page_sel), .carry_in(carry_in), .acc(acc), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .carry_out(carry_out), .flag_n(flag_n), .flag_z(flag_z)
  );

  always @(posedge clk) begin
    if (pl_en) bmem[pl_a] <= pl_d;
    if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];
    if (mem_wr) bmem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic [3:0] o, input logic [15:0] w);
    return (o < 4'd8) ? {3'b000, w[12:0]} : w;
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [15:0] w, input logic [3:0] ps,
                        input logic cin, input logic [7:0] a, input logic [7:0] mv,
                        input bit glitch, input string req);
    logic [15:0] ea;
    logic [2:0]  bi;
    logic        sel, ec, ewr;
    logic [7:0]  ewd, d;
    int nrd, nwr, lat, rd_cyc, wr_cyc;
    logic [15:0] rda, wra;
    logic [7:0]  wrd;
    logic c_s, n_s, z_s;
    ea  = exp_addr(o, w);
    bi  = (o < 4'd8) ? w[15:13] : ps[3:1];
    sel = mv[bi];
    ec  = cin; ewr = 1'b0; ewd = mv;
    d   = a - mv;
    case (o)
      4'd0: ec = cin & sel;
      4'd1: ec = cin & ~sel;
      4'd2: ec = cin | sel;
      4'd3: ec = cin | ~sel;
      4'd4: ec = cin ^ sel;
      4'd5: ec = sel;
      4'd6: begin ewr = 1; ewd[bi] = cin; end
      4'd7: begin ewr = 1; ewd[bi] = ~mv[bi]; end
      4'd8: begin ewr = 1; ewd[bi] = ~ps[0]; end
      4'd9: begin ewr = 1; ewd = (mv & ~a) | a; mdl_n = d[7]; mdl_z = (d == 0); end
      4'd10: begin ewr = 1; ewd = mv & ~a; mdl_n = d[7]; mdl_z = (d == 0); end
      default: ;
    endcase
    @(negedge clk);
    pl_en = 1; pl_a = ea[7:0]; pl_d = mv;
    @(negedge clk);
    pl_en = 0;
    start = 1; op = o; operand = w; page_sel = ps; carry_in = cin; acc = a;
    nrd = 0; nwr = 0; lat = 0; rd_cyc = 0; wr_cyc = 0;
    rda = '0; wra = '0; wrd = '0; c_s = 0; n_s = 0; z_s = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = glitch;
        if (glitch) begin op = 4'd7; operand = ~w; carry_in = ~cin; acc = ~a; end
      end
      if (k == 2) start = 0;
      if (mem_rd) begin nrd++; rda = mem_addr; rd_cyc = k; end
      if (mem_wr) begin nwr++; wra = mem_addr; wrd = mem_wdata; wr_cyc = k; end
      if (done && lat == 0) begin lat = k; c_s = carry_out; n_s = flag_n; z_s = flag_z; end
    end
    check(nrd == 1 && rd_cyc == 1, req, "read strobe count/cycle (R7)", nrd * 16 + rd_cyc, 17);
    check(rda == ea, req, "read address (R1)", rda, ea);
    check(nwr == (ewr ? 1 : 0), req, "write count", nwr, ewr ? 1 : 0);
    if (ewr) begin
      check(wr_cyc == 3, req, "write cycle (R7)", wr_cyc, 3);
      check(wra == ea, req, "write address", wra, ea);
      check(wrd == ewd, req, "write data", wrd, ewd);
    end
    check(lat == (ewr ? 4 : 3), req, "done latency (R7)", lat, ewr ? 4 : 3);
    check(c_s == ec, req, "carry", c_s, ec);
    check(n_s == mdl_n && z_s == mdl_z, req, "N/Z", {n_s, z_s}, {mdl_n, mdl_z});
    check(!busy, req, "idle after done", busy, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D0C));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check(!mem_rd && !mem_wr && !done && !busy, "R9", "strobes after reset",
          {mem_rd, mem_wr, done, busy}, 0);
    check(!carry_out && !flag_n && !flag_z, "R9", "flags after reset",
          {carry_out, flag_n, flag_z}, 0);
    // R1 packed word with all bit-number bits set
    run_op(4'd5, 16'hFFFF, 4'h0, 1'b0, 8'h00, 8'h80, 0, "R1");
    run_op(4'd5, 16'h6005, 4'h0, 1'b1, 8'h00, 8'hF7, 0, "R1");
    // R2 each carry op, both bit values
    for (int o = 0; o < 5; o++) begin
      run_op(4'(o), 16'h4033, 4'h0, 1'b1, 8'h00, 8'h04, 0, "R2");
      run_op(4'(o), 16'h4033, 4'h0, 1'b1, 8'h00, 8'hFB, 0, "R2");
      run_op(4'(o), 16'h4033, 4'h0, 1'b0, 8'h00, 8'h04, 0, "R2");
    end
    // R3 move forms
    run_op(4'd6, 16'hA011, 4'h0, 1'b0, 8'h00, 8'hFF, 0, "R3");
    run_op(4'd6, 16'h2011, 4'h0, 1'b1, 8'h00, 8'h00, 0, "R3");
    // R4 invert
    run_op(4'd7, 16'hE0AA, 4'h0, 1'b1, 8'h00, 8'h5A, 0, "R4");
    // R5 direct-page set/clear, bit 7
    run_op(4'd8, 16'h0142, 4'hE, 1'b0, 8'h00, 8'h00, 0, "R5");
    run_op(4'd8, 16'h0142, 4'hF, 1'b1, 8'h00, 8'hFF, 0, "R5");
    run_op(4'd8, 16'h0003, 4'h3, 1'b0, 8'h00, 8'hFD, 0, "R5");
    // R6 test forms
    run_op(4'd9, 16'h1234, 4'h0, 1'b1, 8'h3C, 8'h3C, 0, "R6");
    run_op(4'd10, 16'h1234, 4'h0, 1'b0, 8'h90, 8'h0F, 0, "R6");
    run_op(4'd10, 16'hBEEF, 4'h0, 1'b1, 8'h01, 8'h02, 0, "R6");
    // R11 flags hold across other ops
    run_op(4'd7, 16'h0077, 4'h0, 1'b0, 8'h00, 8'h11, 0, "R11");
    run_op(4'd8, 16'h0077, 4'h4, 1'b1, 8'h00, 8'h11, 0, "R11");
    // R10 unused codes
    run_op(4'd12, 16'hFF21, 4'h0, 1'b1, 8'hAA, 8'h55, 0, "R10");
    run_op(4'd15, 16'h8001, 4'h9, 1'b0, 8'h00, 8'hFF, 0, "R10");
    // R8 start while busy
    run_op(4'd2, 16'h2050, 4'h0, 1'b0, 8'h00, 8'h02, 1, "R8");
    run_op(4'd9, 16'h3050, 4'h0, 1'b0, 8'h10, 8'h01, 1, "R8");
    // R9 reset mid-operation
    @(negedge clk);
    start = 1; op = 4'd7; operand = 16'h0010;
    @(negedge clk);
    start = 0; rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    check(!mem_rd && !mem_wr && !done && !busy, "R9", "strobes after mid-op reset",
          {mem_rd, mem_wr, done, busy}, 0);
    check(!carry_out && !flag_n && !flag_z, "R9", "flags after mid-op reset",
          {carry_out, flag_n, flag_z}, 0);
    mdl_n = 0; mdl_z = 0;
    repeat (3) @(negedge clk);
    check(!mem_wr && !done, "R9", "no pending write after reset", {mem_wr, done}, 0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      run_op(4'($urandom_range(0, 15)), 16'($urandom), 4'($urandom),
             1'($urandom), 8'($urandom), 8'($urandom), 0, "R2/R6 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule